// File: doc/BRIEF.md
# Restricted Segment Remapping Cache

This block sits between the page-table physical address produced by address translation and the DRAM controllers of a two-tier memory, in which fast and slow 2 KB segments may be swapped by a separate swap engine. Each segment belongs to a fixed group, and every group has exactly one remapping-table entry. The entry index is the segment number modulo the number of fast slots, so the upper bits of the segment number select a member within the group. An entry records which member of its group currently holds the group's fast slot. The member it displaced (member 0, whose home is the fast slot) then lives at the slow location that the promoted member vacated.

A small four-way set-associative cache holds recently used entries. A hit produces a translated address one cycle after acceptance. A miss issues exactly one table read for the single entry that can describe the segment, fills a way, and then returns the translation. Only one miss is outstanding, and new requests are held off while it is pending. The swap engine uses an update port to rewrite a cached entry, so no translation is formed from stale data.

The control is a three-state machine:
- `ST_IDLE` accepts requests.
  - `IDLE->IDLE` is taken on a hit or when no request arrives.
  - `IDLE->ISSUE` is taken on a miss.
- `ST_ISSUE` drives the one-cycle table read, then always moves on (`ISSUE->WAIT`).
- `ST_WAIT` holds until the table response arrives.
  - `WAIT->WAIT` is taken while no response is present.
  - `WAIT->IDLE` is taken on the response, which fills the cache and responds.

Top module: `seg_remap_cache`

## Requirements
- R1: Address bits [10:0] of a request appear unchanged in bits [10:0] of its translated address.
- R2: For segment number s, entry index i = s mod NUM_ENT, member m = s / NUM_ENT, and stored fast member f, the translated segment number is computed as follows, and `resp_fast` is 1 only in the first case:
  - if m == f, the segment number is i, placing the segment in fast memory;
  - otherwise, if m == 0, it is f*NUM_ENT + i;
  - otherwise, it is s.
- R3: A request accepted on a cached entry gives `resp_valid=1` and `resp_hit=1` in the next cycle, and no table read is issued.
- R4: A request accepted on an uncached entry raises `tbl_rd_valid` for exactly one cycle, in the cycle after acceptance, with `tbl_rd_idx = i`. The response follows one cycle after the table response is sampled, with `resp_hit=0`.
- R5: Entry i maps to cache set i mod SETS. Four distinct entries of one set can be cached together, and no entry is ever held in two ways.
- R6: Each set keeps a 3-bit pseudo-LRU tree:
  - the root bit set to 0 names the victim among ways 0/1, and set to 1 names it among ways 2/3;
  - the left bit picks way 1 when set (way 0 when clear), and the right bit picks way 3 when set (way 2 when clear);
  - every hit and every fill points the bits away from the way used;
  - a fill takes the lowest-numbered invalid way if any exists, and otherwise the tree's victim.
- R7: From the acceptance of a miss until its table response is sampled, `req_ready` is 0 and no response is produced.
- R8: After reset, `req_ready=1`, `resp_valid=0`, `tbl_rd_valid=0`, and all ways are invalid, so the first request to any entry misses.
- R9: The update port behaves as follows:
  - an update to a cached entry rewrites its fast member;
  - an update to an uncached entry leaves the cache unchanged and produces no table read or response;
  - an update presented together with a request to the same entry is used by that request;
  - an update to the entry of a pending miss replaces the table response's value.
- R10: `resp_hit` and `resp_fast` together report one of four outcomes: hit-fast, hit-slow, miss-fast or miss-slow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Page-table physical address |
| resp_valid | output | 1 | Translation result valid (one cycle) |
| resp_hit | output | 1 | Result came from the cache |
| resp_fast | output | 1 | Translated address lies in fast memory |
| resp_addr | output | ADDR_W | DRAM physical address |
| tbl_rd_valid | output | 1 | Remapping-table read request |
| tbl_rd_idx | output | IDX_W | Table entry to read |
| tbl_rsp_valid | input | 1 | Table read data present |
| tbl_rsp_fast | input | MEM_W | Fast member stored in the entry read |
| upd_valid | input | 1 | Entry rewrite from the swap engine |
| upd_idx | input | IDX_W | Entry being rewritten |
| upd_fast | input | MEM_W | New fast member |

## Verification
The bench sweeps every member of every group, so that all three mapping branches and all four outcomes are hit. A wrong mapping branch would show up as a translated address off by a multiple of NUM_ENT segments. It then walks a scrambled order of segments through the cache, and a reference model of the tree predicts each hit and miss. A wrong victim choice or a missed tree update would turn a predicted hit into a table read, or the reverse. Updates are sent at the awkward moments: while the entry is uncached, in the same cycle as a request to it, and while its miss is pending. In the last two cases the table answers with the old value, so a design that drops the forwarding or the override returns the stale slot. Table responses are held back for several cycles to catch a design that lets a second request in, or issues the read more than once.

// File: rtl/seg_remap_pkg.sv
package seg_remap_pkg;
    localparam int WAYS   = 4;
    localparam int WAY_W  = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } state_e;
endpackage

// File: rtl/seg_remap_xlate.sv
module seg_remap_xlate #(
    parameter int ADDR_W = 20,
    parameter int OFS_W  = 11,
    parameter int IDX_W  = 6
) (
    input  logic [ADDR_W-1:0]              addr,
    input  logic [ADDR_W-OFS_W-IDX_W-1:0]  fast_mem,
    output logic [ADDR_W-1:0]              dpa,
    output logic                           in_fast
);
    localparam int SEG_W = ADDR_W - OFS_W;
    localparam int MEM_W = SEG_W - IDX_W;

    logic [SEG_W-1:0] seg;
    logic [MEM_W-1:0] member;
    logic [SEG_W-1:0] dseg;

    always_comb begin
        seg    = addr[ADDR_W-1:OFS_W];
        member = seg[SEG_W-1:IDX_W];
        if (member == fast_mem) begin
            dseg    = {{MEM_W{1'b0}}, seg[IDX_W-1:0]};
            in_fast = 1'b1;
        end else if (member == '0) begin
            dseg    = {fast_mem, seg[IDX_W-1:0]};
            in_fast = 1'b0;
        end else begin
            dseg    = seg;
            in_fast = 1'b0;
        end
        dpa = {dseg, addr[OFS_W-1:0]};
    end
endmodule

// File: rtl/seg_remap_plru.sv
module seg_remap_plru
    import seg_remap_pkg::*;
#(
    parameter int SETS  = 4,
    parameter int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] rd_set,
    output logic [WAY_W-1:0] rd_way,
    input  logic             touch_en,
    input  logic [SET_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way
);
    logic [2:0] tree_q [SETS];

    function automatic logic [WAY_W-1:0] pick(input logic [2:0] t);
        return t[0] ? {1'b1, t[2]} : {1'b0, t[1]};
    endfunction

    assign rd_way = pick(tree_q[rd_set]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) tree_q[s] <= 3'b000;
        end else if (touch_en) begin
            tree_q[touch_set][0] <= ~touch_way[1];
            if (!touch_way[1]) tree_q[touch_set][1] <= ~touch_way[0];
            else               tree_q[touch_set][2] <= ~touch_way[0];
        end
    end

    // R6: the way just used is never the next victim of its set
    a_r6_touched_not_victim: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> pick(tree_q[$past(touch_set)]) != $past(touch_way));
endmodule

// File: rtl/seg_remap_tags.sv
module seg_remap_tags
    import seg_remap_pkg::*;
#(
    parameter int SETS   = 4,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 3,
    parameter int SET_W  = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SET_W-1:0]  lk_set,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [WAY_W-1:0]  lk_way,
    output logic [DATA_W-1:0] lk_data,
    input  logic [SET_W-1:0]  fl_set,
    input  logic [WAY_W-1:0]  tree_way,
    output logic [WAY_W-1:0]  fl_way,
    input  logic              fill_en,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              up_en,
    input  logic [SET_W-1:0]  up_set,
    input  logic [TAG_W-1:0]  up_tag,
    input  logic [DATA_W-1:0] up_data
);
    logic [WAYS-1:0]   vld_q [SETS];
    logic [TAG_W-1:0]  tag_q [SETS][WAYS];
    logic [DATA_W-1:0] dat_q [SETS][WAYS];
    logic [WAYS-1:0]   hit_vec;
    logic [WAYS-1:0]   up_vec;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hit_vec[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
        assign up_vec[w]  = vld_q[up_set][w] && (tag_q[up_set][w] == up_tag);
    end

    always_comb begin
        lk_hit  = |hit_vec;
        lk_way  = '0;
        lk_data = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) begin
                lk_way  = WAY_W'(w);
                lk_data = dat_q[lk_set][w];
            end
        end
        fl_way = tree_way;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld_q[fl_set][w]) fl_way = WAY_W'(w);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
        end else if (fill_en) begin
            vld_q[fl_set][fl_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (up_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (up_vec[w]) dat_q[up_set][w] <= up_data;
            end
        end
        if (fill_en) begin
            tag_q[fl_set][fl_way] <= fill_tag;
            dat_q[fl_set][fl_way] <= fill_data;
        end
    end

    // R5: an entry never occupies more than one way of its set
    a_r5_single_way: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/seg_remap_cache.sv
module seg_remap_cache
    import seg_remap_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int OFS_W   = 11,
    parameter int NUM_ENT = 64,
    parameter int SETS    = 4,
    localparam int SEG_W  = ADDR_W - OFS_W,
    localparam int IDX_W  = $clog2(NUM_ENT),
    localparam int MEM_W  = SEG_W - IDX_W,
    localparam int SET_W  = $clog2(SETS),
    localparam int TAG_W  = IDX_W - SET_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_fast,
    output logic [ADDR_W-1:0] resp_addr,
    output logic              tbl_rd_valid,
    output logic [IDX_W-1:0]  tbl_rd_idx,
    input  logic              tbl_rsp_valid,
    input  logic [MEM_W-1:0]  tbl_rsp_fast,
    input  logic              upd_valid,
    input  logic [IDX_W-1:0]  upd_idx,
    input  logic [MEM_W-1:0]  upd_fast
);
    state_e state_q, state_d;

    logic [ADDR_W-1:0] pend_addr;
    logic              pend_ovr;
    logic [MEM_W-1:0]  pend_val;

    logic [IDX_W-1:0]  req_idx, pend_idx;
    logic              accept, lk_hit, fill_en;
    logic [WAY_W-1:0]  lk_way, fl_way, tree_way;
    logic [MEM_W-1:0]  lk_data, hit_val, fill_val;
    logic              upd_req, upd_pend;
    logic [ADDR_W-1:0] x_addr, x_dpa;
    logic [MEM_W-1:0]  x_fast_mem;
    logic              x_fast;

    assign req_idx  = req_addr[OFS_W+IDX_W-1:OFS_W];
    assign pend_idx = pend_addr[OFS_W+IDX_W-1:OFS_W];
    assign accept   = req_valid && (state_q == ST_IDLE);
    assign upd_req  = upd_valid && (upd_idx == req_idx);
    assign upd_pend = upd_valid && (upd_idx == pend_idx);
    assign fill_en  = (state_q == ST_WAIT) && tbl_rsp_valid;
    assign hit_val  = upd_req ? upd_fast : lk_data;
    assign fill_val = upd_pend ? upd_fast : (pend_ovr ? pend_val : tbl_rsp_fast);
    assign x_addr     = (state_q == ST_IDLE) ? req_addr : pend_addr;
    assign x_fast_mem = (state_q == ST_IDLE) ? hit_val : fill_val;

    seg_remap_tags #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(MEM_W)) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_set    (req_idx[SET_W-1:0]),
        .lk_tag    (req_idx[IDX_W-1:SET_W]),
        .lk_hit    (lk_hit),
        .lk_way    (lk_way),
        .lk_data   (lk_data),
        .fl_set    (pend_idx[SET_W-1:0]),
        .tree_way  (tree_way),
        .fl_way    (fl_way),
        .fill_en   (fill_en),
        .fill_tag  (pend_idx[IDX_W-1:SET_W]),
        .fill_data (fill_val),
        .up_en     (upd_valid),
        .up_set    (upd_idx[SET_W-1:0]),
        .up_tag    (upd_idx[IDX_W-1:SET_W]),
        .up_data   (upd_fast)
    );

    seg_remap_plru #(.SETS(SETS)) u_plru (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_set    (pend_idx[SET_W-1:0]),
        .rd_way    (tree_way),
        .touch_en  ((accept && lk_hit) || fill_en),
        .touch_set (fill_en ? pend_idx[SET_W-1:0] : req_idx[SET_W-1:0]),
        .touch_way (fill_en ? fl_way : lk_way)
    );

    seg_remap_xlate #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_xlate (
        .addr     (x_addr),
        .fast_mem (x_fast_mem),
        .dpa      (x_dpa),
        .in_fast  (x_fast)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept && !lk_hit) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (tbl_rsp_valid) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        req_ready    = (state_q == ST_IDLE);
        tbl_rd_valid = (state_q == ST_ISSUE);
        tbl_rd_idx   = pend_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_addr  <= '0;
            pend_ovr   <= 1'b0;
            pend_val   <= '0;
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_fast  <= 1'b0;
            resp_addr  <= '0;
        end else begin
            resp_valid <= 1'b0;
            if (accept && !lk_hit) begin
                pend_addr <= req_addr;
                pend_ovr  <= upd_req;
                pend_val  <= upd_fast;
            end else if (state_q != ST_IDLE && upd_pend) begin
                pend_ovr <= 1'b1;
                pend_val <= upd_fast;
            end
            if ((accept && lk_hit) || fill_en) begin
                resp_valid <= 1'b1;
                resp_hit   <= accept;
                resp_fast  <= x_fast;
                resp_addr  <= x_dpa;
            end
        end
    end

    // R3: cached entry answers next cycle without touching the table
    a_r3_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && lk_hit) |=> (resp_valid && resp_hit && !tbl_rd_valid));
    // R4: a miss fetches exactly its own entry in the following cycle
    a_r4_miss_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !lk_hit) |=>
            (tbl_rd_valid && tbl_rd_idx == $past(req_addr[OFS_W+IDX_W-1:OFS_W])));
    // R4: the table read lasts a single cycle
    a_r4_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_rd_valid |=> !tbl_rd_valid);
    // R7: nothing is accepted while the fetch is pending
    a_r7_stall: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_rd_valid |=> !req_ready);
    // R1: segment offset passes through on a hit
    a_r1_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_hit) |-> resp_addr[OFS_W-1:0] == $past(req_addr[OFS_W-1:0]));
endmodule

// File: tb/seg_remap_cache_tb.sv
module seg_remap_cache_tb;
    localparam int ADDR_W = 20;
    localparam int NE     = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [19:0] req_addr = '0;
    logic        resp_valid, resp_hit, resp_fast;
    logic [19:0] resp_addr;
    logic        tbl_rd_valid;
    logic [5:0]  tbl_rd_idx;
    logic        tbl_rsp_valid = 1'b0;
    logic [2:0]  tbl_rsp_fast = '0;
    logic        upd_valid = 1'b0;
    logic [5:0]  upd_idx = '0;
    logic [2:0]  upd_fast = '0;

    int checks = 0;
    int errors = 0;

    logic [2:0] tbl [NE];
    bit         mv [4][4];
    logic [3:0] mt [4][4];
    logic [2:0] mtree [4];

    always #5 clk = ~clk;

    seg_remap_cache u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_fast(resp_fast), .resp_addr(resp_addr), .tbl_rd_valid(tbl_rd_valid),
        .tbl_rd_idx(tbl_rd_idx), .tbl_rsp_valid(tbl_rsp_valid),
        .tbl_rsp_fast(tbl_rsp_fast), .upd_valid(upd_valid), .upd_idx(upd_idx),
        .upd_fast(upd_fast)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [20:0] expect_x(input logic [19:0] a, input logic [2:0] f);
        logic [8:0] seg, dseg;
        logic       fast;
        seg = a[19:11];
        if (seg[8:6] == f) begin
            dseg = {3'd0, seg[5:0]}; fast = 1'b1;
        end else if (seg[8:6] == 3'd0) begin
            dseg = {f, seg[5:0]}; fast = 1'b0;
        end else begin
            dseg = seg; fast = 1'b0;
        end
        return {fast, dseg, a[10:0]};
    endfunction

    function automatic void m_touch(input int s, input int w);
        mtree[s][0] = (w < 2);
        if (w < 2) mtree[s][1] = (w == 0);
        else       mtree[s][2] = (w == 2);
    endfunction

    function automatic int m_find(input logic [5:0] idx);
        for (int w = 0; w < 4; w++)
            if (mv[idx[1:0]][w] && mt[idx[1:0]][w] == idx[5:2]) return w;
        return -1;
    endfunction

    function automatic void m_fill(input logic [5:0] idx);
        int s, v;
        s = idx[1:0];
        v = -1;
        for (int w = 3; w >= 0; w--) if (!mv[s][w]) v = w;
        if (v < 0) v = mtree[s][0] ? (2 + mtree[s][2]) : mtree[s][1];
        mv[s][v] = 1'b1;
        mt[s][v] = idx[5:2];
        m_touch(s, v);
    endfunction

    // mode 0: plain; 1: update to same entry with the request; 2: update during the wait
    task automatic access(input logic [19:0] a, input int hold, input int mode, input logic [2:0] nv);
        logic [5:0]  idx;
        logic [2:0]  old_f;
        logic [20:0] ex;
        int          w;
        idx   = a[16:11];
        old_f = tbl[idx];
        req_valid = 1'b1;
        req_addr  = a;
        if (mode == 1) begin
            upd_valid = 1'b1; upd_idx = idx; upd_fast = nv; tbl[idx] = nv;
        end
        w = m_find(idx);
        @(negedge clk);
        req_valid = 1'b0;
        upd_valid = 1'b0;
        if (w >= 0) begin
            ex = expect_x(a, tbl[idx]);
            chk("R3 hit resp_valid", resp_valid, 1);
            chk("R3 hit resp_hit", resp_hit, 1);
            chk("R3 hit no table read", tbl_rd_valid, 0);
            chk("R2 hit address", resp_addr, ex[19:0]);
            chk("R10 hit fast flag", resp_fast, ex[20]);
            chk("R1 offset", resp_addr[10:0], a[10:0]);
            m_touch(idx[1:0], w);
        end else begin
            chk("R4 read issued", tbl_rd_valid, 1);
            chk("R4 read index", tbl_rd_idx, idx);
            chk("R7 ready low on miss", req_ready, 0);
            @(negedge clk);
            chk("R4 single read", tbl_rd_valid, 0);
            if (mode == 2) begin
                upd_valid = 1'b1; upd_idx = idx; upd_fast = nv; tbl[idx] = nv;
                @(negedge clk);
                upd_valid = 1'b0;
            end
            for (int h = 0; h < hold; h++) begin
                chk("R7 stalled ready", req_ready, 0);
                chk("R7 no early resp", resp_valid, 0);
                @(negedge clk);
            end
            tbl_rsp_valid = 1'b1;
            tbl_rsp_fast  = (mode != 0) ? old_f : tbl[idx];
            @(negedge clk);
            tbl_rsp_valid = 1'b0;
            ex = expect_x(a, tbl[idx]);
            chk("R4 miss resp_valid", resp_valid, 1);
            chk("R4 miss resp_hit", resp_hit, 0);
            chk("R2 miss address", resp_addr, ex[19:0]);
            chk("R10 miss fast flag", resp_fast, ex[20]);
            chk("R7 ready back", req_ready, 1);
            m_fill(idx);
        end
    endtask

    task automatic upd(input logic [5:0] idx, input logic [2:0] v);
        upd_valid = 1'b1; upd_idx = idx; upd_fast = v;
        @(negedge clk);
        upd_valid = 1'b0;
        tbl[idx] = v;
        chk("R9 update alone gives no read", tbl_rd_valid, 0);
        chk("R9 update alone gives no resp", resp_valid, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NE; i++) tbl[i] = '0;
        for (int s = 0; s < 4; s++) begin
            mtree[s] = '0;
            for (int w = 0; w < 4; w++) begin mv[s][w] = 0; mt[s][w] = '0; end
        end
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8 ready after reset", req_ready, 1);
        chk("R8 no resp after reset", resp_valid, 0);
        chk("R8 no read after reset", tbl_rd_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: updates to uncached entries are ignored by the cache
        for (int i = 0; i < NE; i++) upd(6'(i), 3'((i * 5 + 3) % 8));
        // R2 R10 R8: every member of every group; first access to each entry misses
        for (int i = 0; i < NE; i++)
            for (int m = 0; m < 8; m++)
                access({3'(m), 6'(i), 11'((i * 131 + m * 7) % 2048)}, m % 3, 0, '0);
        // R5 R6: scrambled order, hit/miss predicted by the tree model
        for (int k = 0; k < 512; k++)
            access({9'((k * 97) % 512), 11'((k * 37) % 2048)}, k % 4, 0, '0);
        // R6: directed fill of set 1, reuse, then one eviction
        for (int t = 0; t < 6; t++) access({3'd2, 4'(t), 2'd1, 11'h0A5}, 0, 0, '0);
        access({3'd2, 4'd1, 2'd1, 11'h0A5}, 0, 0, '0);
        access({3'd2, 4'd9, 2'd1, 11'h0A5}, 0, 0, '0);
        for (int t = 0; t < 6; t++) access({3'd1, 4'(t), 2'd1, 11'h3C3}, 1, 0, '0);
        // R9: rewrite of a cached entry
        access({3'd0, 6'd5, 11'h111}, 0, 0, '0);
        upd(6'd5, 3'd6);
        access({3'd6, 6'd5, 11'h222}, 0, 0, '0);
        access({3'd0, 6'd5, 11'h333}, 0, 0, '0);
        // R9: update presented with a request to the same cached entry
        access({3'd4, 6'd5, 11'h444}, 0, 1, 3'd4);
        access({3'd4, 6'd5, 11'h555}, 0, 0, '0);
        // R9: same-cycle update on a miss, table answers stale
        access({3'd3, 6'd62, 11'h001}, 2, 1, 3'd3);
        access({3'd3, 6'd62, 11'h002}, 0, 0, '0);
        // R9: update during a pending miss, table answers stale
        access({3'd7, 6'd61, 11'h7FF}, 1, 2, 3'd7);
        access({3'd0, 6'd61, 11'h000}, 0, 0, '0);
        // R7: long stall on a fresh miss
        access({3'd5, 6'd60, 11'h123}, 6, 0, '0);
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule